// File: doc/BRIEF.md
# SDRAM Power-On Initialization and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable. After reset it drives a fixed start-up order: a long idle phase of no-operation commands with clock enable and the data masks held high, then a precharge of every bank, a run of auto-refresh commands, and finally a mode register load built from configuration inputs. Each step waits its own timing window before the next command. Once the last window closes, the block raises `ready` and keeps it high.

In the ready phase it runs a refresh interval timer. The interval comes from the row count and the retention period: `CLK_MHZ * REF_MS * 1000 / ROWS` cycles, which is 1953 cycles at 125 MHz for 4096 rows in 64 ms. On each expiry it raises `ref_req`. A later arbiter answers with `ref_ack`, and the block then issues one auto-refresh command and waits the row cycle time. The block carries no read or write traffic.

The states are PWRUP, PREA, PREA_WAIT, IREF, IREF_WAIT, MRS, MRS_WAIT, READY, REF and REF_WAIT. The transitions are as follows. PWRUP goes to PREA when the power-up wait ends. PREA goes to PREA_WAIT. PREA_WAIT goes to IREF when tRP ends. IREF goes to IREF_WAIT. IREF_WAIT goes back to IREF when tRC ends, or to MRS once `INIT_REFS` refreshes have been issued. MRS goes to MRS_WAIT. MRS_WAIT goes to READY when tRSC ends. READY goes to REF when a request is acknowledged. REF goes to REF_WAIT. REF_WAIT goes back to READY when tRC ends.

Top module: `sdram_init_seq`

## Requirements
- R1: Throughout reset and until `ready` rises, `cke` is 1 and every `dqm` bit is 1. The first `PWR_CYC = CLK_MHZ*PWR_US` cycles after reset are no-operation cycles, coded as cs_n,ras_n,cas_n,we_n = 0,1,1,1.
- R2: The first command after the idle phase is precharge-all, coded as 0,0,1,0, with addr[10]=1 and all other address and bank bits 0. It appears in cycle `PWR_CYC` after reset release.
- R3: The first auto-refresh follows the precharge after exactly `TRP_CYC` cycles.
- R4: Exactly `INIT_REFS` auto-refresh commands, coded as 0,0,0,1, are issued during start-up. Each one follows the previous one after `TRC_CYC` cycles.
- R5: The mode register load, coded as 0,0,0,0, follows the last start-up refresh after `TRC_CYC` cycles.
- R6: In the mode word, addr[2:0] holds the burst length code, addr[3] the burst type, addr[6:4] the CAS latency code and addr[9] the write mode. addr[8:7], addr[11:10] and `ba` are 0.
- R7: Legal burst length codes are 000, 001, 010 and 011; 111 is legal only with burst type 0. Any other burst length code is written as 011. A CAS latency code other than 010 or 011 is written as 011.
- R8: `ready` rises `TRSC_CYC` cycles after the mode register load and never falls before the next reset. While `ready` is high, `dqm` is all 0.
- R9: `ref_req` rises `REF_INT` cycles after `ready` rises and again every `REF_INT` cycles. It stays high until it is accepted.
- R10: When `ref_req` and `ref_ack` are both high in an idle ready cycle, the next cycle carries an auto-refresh command and `ref_req` is low in that cycle. An acknowledge while no request is pending produces no command.
- R11: An acknowledge held high through a refresh recovery is taken in the first idle ready cycle. The next refresh then follows the previous one after `TRC_CYC+1` cycles.
- R12: If the interval expires in the same cycle as an accepted acknowledge, the refresh is issued and `ref_req` stays high for the new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 3 | Burst length code |
| cfg_bt | input | 1 | Burst type (0 sequential, 1 interleaved) |
| cfg_cl | input | 3 | CAS latency code |
| cfg_wm | input | 1 | Write mode (0 burst, 1 single location) |
| ref_ack | input | 1 | Arbiter grant for a pending refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Data masks |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| ready | output | 1 | Start-up finished |
| ref_req | output | 1 | Refresh request to the arbiter |

## Verification
Two things can happen in the same cycle: the refresh interval timer expires, and an arbiter acknowledge is accepted for the request already pending. The bench leaves the first request of one interval unanswered and raises `ref_ack` in exactly the cycle where the next interval ends. It expects a refresh in the following cycle while `ref_req` stays high. It then keeps the acknowledge high through the recovery time and expects the second refresh one cycle after tRC, with the request cleared.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PREA,
        ST_PREA_WAIT,
        ST_IREF,
        ST_IREF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_READY,
        ST_REF,
        ST_REF_WAIT
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_wait_timer.sv
// Shared down-counter for all start-up and recovery windows.
module sdram_wait_timer #(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0) && !load;
endmodule

// File: rtl/sdram_refresh_timer.sv
// Free-running interval timer with a sticky request bit.
module sdram_refresh_timer #(
    parameter int unsigned INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic take,
    output logic req
);
    localparam int unsigned W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;
    logic         expire;

    assign expire = en && (cnt == W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            req <= 1'b0;
        end else begin
            if (!en || expire) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (expire) begin
                req <= 1'b1;
            end else if (take) begin
                req <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdram_mode_word.sv
// Builds the mode register word and replaces reserved codes.
module sdram_mode_word #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2
) (
    input  logic [2:0]        bl,
    input  logic              bt,
    input  logic [2:0]        cl,
    input  logic              wm,
    output logic [ADDR_W-1:0] mode_addr,
    output logic [BA_W-1:0]   mode_ba
);
    logic [2:0] bl_ok;
    logic [2:0] cl_ok;

    always_comb begin
        if (bl <= 3'd3 || (bl == 3'd7 && !bt)) begin
            bl_ok = bl;
        end else begin
            bl_ok = 3'd3;
        end
        if (cl == 3'd2 || cl == 3'd3) begin
            cl_ok = cl;
        end else begin
            cl_ok = 3'd3;
        end
        mode_addr      = '0;
        mode_addr[2:0] = bl_ok;
        mode_addr[3]   = bt;
        mode_addr[6:4] = cl_ok;
        mode_addr[9]   = wm;
        mode_ba        = '0;
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 125,
    parameter int unsigned PWR_US    = 200,
    parameter int unsigned TRP_CYC   = 3,
    parameter int unsigned TRC_CYC   = 9,
    parameter int unsigned TRSC_CYC  = 2,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned ROWS      = 4096,
    parameter int unsigned REF_MS    = 64,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned DQM_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_bl,
    input  logic              cfg_bt,
    input  logic [2:0]        cfg_cl,
    input  logic              cfg_wm,
    input  logic              ref_ack,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              ref_req
);
    localparam int unsigned PWR_CYC = CLK_MHZ * PWR_US;
    localparam int unsigned REF_INT = CLK_MHZ * REF_MS * 1000 / ROWS;
    localparam int unsigned TMAX    = (PWR_CYC > TRC_CYC) ? PWR_CYC : TRC_CYC;
    localparam int unsigned TW      = $clog2(TMAX + 1);
    localparam int unsigned RCW     = $clog2(INIT_REFS + 1);

    seq_state_t        st, st_nx;
    logic [RCW-1:0]    irc;
    logic              t_load, t_done, take;
    logic [TW-1:0]     t_val;
    logic [ADDR_W-1:0] mode_addr;
    logic [BA_W-1:0]   mode_ba;
    sd_cmd_t           cmd;

    sdram_wait_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    sdram_refresh_timer #(.INTERVAL(REF_INT)) u_rtmr (
        .clk(clk), .rst_n(rst_n), .en(ready), .take(take), .req(ref_req)
    );

    sdram_mode_word #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
        .bl(cfg_bl), .bt(cfg_bt), .cl(cfg_cl), .wm(cfg_wm),
        .mode_addr(mode_addr), .mode_ba(mode_ba)
    );

    assign take = (st == ST_READY) && ref_req && ref_ack;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_PWRUP;
            irc <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IREF) begin
                irc <= irc + 1'b1;
            end
        end
    end

    // next state and window loads
    always_comb begin
        st_nx  = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            ST_PWRUP:     if (t_done) st_nx = ST_PREA;
            ST_PREA: begin
                st_nx  = ST_PREA_WAIT;
                t_load = 1'b1;
                t_val  = TW'(TRP_CYC - 2);
            end
            ST_PREA_WAIT: if (t_done) st_nx = ST_IREF;
            ST_IREF: begin
                st_nx  = ST_IREF_WAIT;
                t_load = 1'b1;
                t_val  = TW'(TRC_CYC - 2);
            end
            ST_IREF_WAIT: if (t_done) st_nx = (irc == RCW'(INIT_REFS)) ? ST_MRS : ST_IREF;
            ST_MRS: begin
                st_nx  = ST_MRS_WAIT;
                t_load = 1'b1;
                t_val  = TW'(TRSC_CYC - 2);
            end
            ST_MRS_WAIT:  if (t_done) st_nx = ST_READY;
            ST_READY:     if (take) st_nx = ST_REF;
            ST_REF: begin
                st_nx  = ST_REF_WAIT;
                t_load = 1'b1;
                t_val  = TW'(TRC_CYC - 2);
            end
            ST_REF_WAIT:  if (t_done) st_nx = ST_READY;
            default:      st_nx = ST_PWRUP;
        endcase
    end

    // outputs
    always_comb begin
        cmd   = CMD_NOP;
        addr  = '0;
        ba    = '0;
        dqm   = '1;
        ready = 1'b0;
        unique case (st)
            ST_PWRUP, ST_PREA_WAIT, ST_IREF_WAIT, ST_MRS_WAIT: ;
            ST_PREA: begin
                cmd      = CMD_PREA;
                addr[10] = 1'b1;
            end
            ST_IREF:  cmd = CMD_AREF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_addr;
                ba   = mode_ba;
            end
            ST_READY, ST_REF_WAIT: begin
                dqm   = '0;
                ready = 1'b1;
            end
            ST_REF: begin
                cmd   = CMD_AREF;
                dqm   = '0;
                ready = 1'b1;
            end
            default: ;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign cke   = 1'b1;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned DQM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic [DQM_W-1:0]  dqm,
    input logic              ready,
    input logic              ref_req,
    input logic              ref_ack
);
    logic [3:0] c;
    assign c = {cs_n, ras_n, cas_n, we_n};

    // R1: masks stay set until start-up is complete
    p_dqm_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (dqm == '1));

    // R2: precharge-all carries the all-banks flag
    p_prea_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> (addr[10] && ba == '0));

    // R6: unused mode bits and bank bits are zero
    p_mrs_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (ba == '0 && addr[8:7] == 2'b00 && addr[ADDR_W-1:10] == '0));

    // R7: only legal codes reach the mode register
    p_mrs_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> ((addr[6:4] == 3'd2 || addr[6:4] == 3'd3) &&
                            (addr[2:0] <= 3'd3 || (addr[2:0] == 3'd7 && !addr[3]))));

    // R8: ready is sticky
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R9: a request is held until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> ref_req);

    // R10: a ready-phase refresh always follows an acknowledged request
    p_ref_acked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && c == 4'b0001) |-> $past(ref_req && ref_ack));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .ready(ready),
    .ref_req(ref_req), .ref_ack(ref_ack)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
    localparam int CLK_MHZ = 125;
    localparam int PWR_US  = 2;
    localparam int TRP     = 3;
    localparam int TRC     = 9;
    localparam int TRSC    = 2;
    localparam int NREF    = 8;
    localparam int PWR     = CLK_MHZ * PWR_US;
    localparam int RINT    = CLK_MHZ * 64 * 1000 / 4096;

    // {bl, bt, cl, wm, expected mode word}
    localparam logic [19:0] VEC [7] = '{
        {3'b010, 1'b0, 3'b011, 1'b0, 12'h032},
        {3'b011, 1'b1, 3'b010, 1'b1, 12'h22B},
        {3'b111, 1'b0, 3'b011, 1'b0, 12'h037},
        {3'b111, 1'b1, 3'b010, 1'b0, 12'h02B},
        {3'b101, 1'b0, 3'b001, 1'b0, 12'h033},
        {3'b000, 1'b1, 3'b111, 1'b1, 12'h238},
        {3'b001, 1'b0, 3'b000, 1'b0, 12'h031}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bl = 3'b010;
    logic        cfg_bt = 1'b0;
    logic [2:0]  cfg_cl = 3'b011;
    logic        cfg_wm = 1'b0;
    logic        ref_ack = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n, cke, ready, ref_req;
    logic [7:0]  dqm;
    logic [1:0]  ba;
    logic [11:0] addr;

    always #4 clk = ~clk;

    sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PWR_US(PWR_US), .TRP_CYC(TRP),
                     .TRC_CYC(TRC), .TRSC_CYC(TRSC), .INIT_REFS(NREF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt),
        .cfg_cl(cfg_cl), .cfg_wm(cfg_wm), .ref_ack(ref_ack),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .dqm(dqm), .ba(ba), .addr(addr), .ready(ready), .ref_req(ref_req)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int t_pre, t_rf, t_rl, n_refs, t_mrs, t_rdy, n_other, n_dqm_bad, n_gap_bad, rc;
    logic [11:0] pre_a, mrs_a;
    logic [1:0]  pre_b, mrs_b;

    function automatic logic [3:0] cmdv();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        rc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_init();
        t_pre = -1; t_rf = -1; t_rl = -1; t_mrs = -1; t_rdy = -1;
        n_refs = 0; n_other = 0; n_dqm_bad = 0; n_gap_bad = 0;
        for (int n = 1; n <= 3000; n++) begin
            @(negedge clk);
            case (cmdv())
                4'b0111: ;
                4'b0010: begin t_pre = n; pre_a = addr; pre_b = ba; end
                4'b0001: begin
                    if (n_refs > 0 && n - t_rl != TRC) n_gap_bad++;
                    if (n_refs == 0) t_rf = n;
                    t_rl = n;
                    n_refs++;
                end
                4'b0000: begin t_mrs = n; mrs_a = addr; mrs_b = ba; end
                default: n_other++;
            endcase
            if (!ready && dqm != 8'hFF) n_dqm_bad++;
            if (ready) begin
                t_rdy = n;
                break;
            end
        end
    endtask

    initial begin
        int bad;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(cke == 1'b1 && dqm == 8'hFF, "R1 reset cke/dqm", {cke, dqm}, 9'h1FF);
        chk(cmdv() == 4'b0111, "R1 reset NOP", cmdv(), 4'b0111);
        chk(!ready && !ref_req, "R1 reset ready/req", {ready, ref_req}, 0);

        // directed start-up run
        do_reset();
        run_init();
        chk(t_pre == PWR, "R1 idle length before precharge", t_pre, PWR);
        chk(n_other == 0 && n_dqm_bad == 0, "R1 only NOP, masks high", n_other + n_dqm_bad, 0);
        chk(pre_a == 12'h400 && pre_b == 2'b00, "R2 precharge-all address", {pre_b, pre_a}, 14'h0400);
        chk(t_rf - t_pre == TRP, "R3 tRP gap", t_rf - t_pre, TRP);
        chk(n_refs == NREF, "R4 start-up refresh count", n_refs, NREF);
        chk(n_gap_bad == 0, "R4 tRC spacing", n_gap_bad, 0);
        chk(t_mrs - t_rl == TRC, "R5 mode load after last refresh", t_mrs - t_rl, TRC);
        chk(t_rdy - t_mrs == TRSC, "R8 ready after tRSC", t_rdy - t_mrs, TRSC);
        chk(dqm == 8'h00, "R8 masks low when ready", dqm, 0);

        // refresh handshake
        rc = 0;
        while (!ref_req && rc < RINT + 10) tick();
        chk(rc == RINT, "R9 first request", rc, RINT);
        bad = 0;
        repeat (100) begin
            tick();
            if (!ref_req || cmdv() == 4'b0001 || !ready) bad++;
        end
        chk(bad == 0, "R9 request held without ack", bad, 0);
        ref_ack = 1'b1;
        tick();
        chk(cmdv() == 4'b0001, "R10 refresh after ack", cmdv(), 4'b0001);
        chk(!ref_req, "R10 request cleared", ref_req, 0);
        bad = 0;
        repeat (20) begin
            tick();
            if (cmdv() == 4'b0001 || ref_req) bad++;
        end
        ref_ack = 1'b0;
        chk(bad == 0, "R10 ack without request ignored", bad, 0);
        while (!ref_req && rc < 2 * RINT + 10) tick();
        chk(rc == 2 * RINT, "R9 periodic request", rc, 2 * RINT);

        // R12: ack lands in the expiry cycle
        while (rc < 3 * RINT - 1) tick();
        chk(ref_req, "R12 request pending before collision", ref_req, 1);
        ref_ack = 1'b1;
        tick();
        chk(cmdv() == 4'b0001, "R12 refresh issued", cmdv(), 4'b0001);
        chk(ref_req, "R12 new request kept", ref_req, 1);
        // R11: held ack waits out the recovery
        bad = 0;
        repeat (TRC) begin
            tick();
            if (cmdv() == 4'b0001) bad++;
        end
        chk(bad == 0, "R11 no refresh inside tRC", bad, 0);
        tick();
        chk(cmdv() == 4'b0001, "R11 second refresh at tRC+1", cmdv(), 4'b0001);
        chk(!ref_req, "R11 request cleared", ref_req, 0);
        ref_ack = 1'b0;

        // mode word table (R6 legal, R7 substituted)
        for (int i = 0; i < 7; i++) begin
            {cfg_bl, cfg_bt, cfg_cl, cfg_wm} = VEC[i][19:12];
            do_reset();
            run_init();
            if (i < 3)
                chk(mrs_a == VEC[i][11:0] && mrs_b == 2'b00, "R6 mode word", {mrs_b, mrs_a}, VEC[i][11:0]);
            else
                chk(mrs_a == VEC[i][11:0] && mrs_b == 2'b00, "R7 reserved code mode word", {mrs_b, mrs_a}, VEC[i][11:0]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule